// File: doc/BRIEF.md
# Pipeline Stage Skid-Buffer Controller

This block is the flow-control core of one in-order pipeline stage with a single thread. Each cycle an upstream producer presents a bundle of up to FW entries. Any entry may carry a kill mark, meaning it was squashed upstream. The stage forwards up to W live entries per cycle to the next stage. When it cannot forward everything, it parks the surplus in a skid buffer. That buffer holds `LAT*FW + W` entries, so it covers the bundles still in flight from upstream after a stop request.

Three downstream consumers can each raise a block request and later an unblock request. The stage keeps one sticky stall flag per consumer. It tells the upstream producer to stop or resume with single-cycle pulses, not with a level ready signal. A squash command empties the stage. A squash hold keeps the stage squashing for as long as it is raised. After the stage leaves the blocked condition, it first drains the skid buffer and only then resumes forwarding directly. Entries always leave in the order they arrived.

Top module: `skid_stage`

## Requirements
- R1: After reset the stage is Idle, forwards nothing, raises no pulse, has all stall flags clear, has the skid buffer empty, and holds `stageActive` and `overflowErr` low.
- R2: In Running or Idle, live entries of the incoming bundle leave in arrival order on lanes 0 upward, up to W of them. Entries with their kill bit set are dropped and take no lane. Valid lanes are always contiguous from lane 0.
- R3: A block request sets that source's stall flag. An unblock request clears it, and an unblock wins if both arrive in the same cycle. While any flag is set the stage forwards nothing, and every live incoming entry goes to the skid buffer. The stage enters Blocked, and `upBlock` pulses only if the state was not already Blocked.
- R4: In Running or Idle with more than W live entries, the first W leave and the rest go to the skid buffer. The state becomes Blocked and `upBlock` pulses.
- R5: In Blocked, once all stall flags are clear, the stage enters Unblocking. In that same cycle it forwards up to W entries from the skid head, and new live entries are appended behind the remaining ones. If the skid buffer was already empty, the stage instead pulses `upUnblock` and behaves as Running in that cycle.
- R6: In Unblocking, when the skid buffer is empty after the cycle's removals and appends, `upUnblock` pulses and the state becomes Running. Otherwise the state stays Unblocking. `stageActive` is high exactly while the state is Unblocking.
- R7: A squash command has the highest priority. It empties the skid buffer, discards the incoming bundle, forwards nothing, and moves to Squashing. It pulses `upUnblock` if the state was Blocked or Unblocking.
- R8: A squash hold, when no squash command is present, overrides any stall. It has the same effect as R7 on the buffer, the outputs, the pulse and the next state.
- R9: Squashing moves to Running on the first cycle with no squash command, no hold and no set stall flag, and it forwards that cycle's bundle as Running. A stall in that cycle leads to Blocked with an `upBlock` pulse.
- R10: The skid buffer holds `LAT*FW + W` entries. Entries pushed beyond that are dropped, and `overflowErr` is set and stays set until reset.
- R11: `upBlock` and `upUnblock` are never high together. Consider the stage leaving Blocked with an empty skid buffer and more than W live entries arriving. It forwards W entries, stays Blocked, and raises neither pulse.
- R12: `stateOut` encodes Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | FW | Incoming bundle entry present, one bit per slot |
| inKill | input | FW | Incoming entry already squashed, drop it |
| inData | input | FW x DW | Incoming entry payloads, slot 0 oldest |
| blockReq | input | 3 | Block request pulse from each downstream source |
| unblockReq | input | 3 | Unblock request pulse from each downstream source |
| squashCmd | input | 1 | Flush the stage this cycle |
| squashHold | input | 1 | Keep the stage squashing this cycle |
| outValid | output | W | Forwarded lane valid, contiguous from lane 0 |
| outData | output | W x DW | Forwarded payloads, lane 0 oldest |
| upBlock | output | 1 | One-cycle request for upstream to stop |
| upUnblock | output | 1 | One-cycle request for upstream to resume |
| stageActive | output | 1 | Stage is draining its skid buffer |
| overflowErr | output | 1 | Sticky skid-buffer overflow flag |
| stateOut | output | 3 | Current state, encoding per R12 |

## Verification
The assertions assume a well-behaved downstream protocol. A source sends an unblock request only while its own stall flag is set, so a flag is never cleared without having been set. The port checks do not see these flags, so the stimulus keeps the rule itself: the bench tracks every flag in its reference model and masks each random unblock request with that model's flags. Long random stalls with full bundles push the skid buffer past its capacity on purpose. Resets between phases with different stall densities then start the sticky error flag clean again.

// File: rtl/skid_stage_pkg.sv
package skid_stage_pkg;

  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RUN        = 3'd1,
    ST_BLOCKED    = 3'd2,
    ST_UNBLOCKING = 3'd3,
    ST_SQUASHING  = 3'd4
  } stageState_e;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic             flush;     // empty the skid buffer
    logic             fromSkid;  // output lanes read from skid head
    logic [CNT_W-1:0] outCnt;    // number of output lanes valid
    logic [CNT_W-1:0] popCnt;    // entries removed from skid head
    logic [CNT_W-1:0] pushStart; // first compacted live entry to store
    logic [CNT_W-1:0] pushCnt;   // number of compacted live entries to store
  } dpCtl_t;

endpackage

// File: rtl/skid_stage_ctrl.sv
module skid_stage_ctrl
  import skid_stage_pkg::*;
#(
  parameter int W    = 2,
  parameter int NSRC = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  blockReq,
  input  logic [NSRC-1:0]  unblockReq,
  input  logic             squashCmd,
  input  logic             squashHold,
  input  logic [CNT_W-1:0] liveCnt,
  input  logic [CNT_W-1:0] skidCnt,
  output dpCtl_t           ctl,
  output logic             upBlock,
  output logic             upUnblock,
  output stageState_e      state
);

  localparam logic [CNT_W-1:0] WC = CNT_W'(W);

  stageState_e stateQ, nextState, decState;
  logic [NSRC-1:0] stallQ, stallUpd;
  logic anyStall;
  logic [CNT_W-1:0] drainN, fwdN, remain;

  assign stallUpd = (stallQ | blockReq) & ~unblockReq;
  assign anyStall = |stallUpd;
  assign drainN   = (skidCnt < WC) ? skidCnt : WC;
  assign fwdN     = (liveCnt < WC) ? liveCnt : WC;
  assign remain   = skidCnt - drainN + liveCnt;

  always_comb begin
    ctl       = '0;
    nextState = stateQ;
    decState  = stateQ;
    upBlock   = 1'b0;
    upUnblock = 1'b0;
    if (squashCmd || squashHold) begin
      ctl.flush = 1'b1;
      nextState = ST_SQUASHING;
      upUnblock = (stateQ == ST_BLOCKED) || (stateQ == ST_UNBLOCKING);
    end else if (anyStall) begin
      ctl.pushCnt = liveCnt;
      upBlock     = (stateQ != ST_BLOCKED);
      nextState   = ST_BLOCKED;
    end else begin
      if (stateQ == ST_BLOCKED) begin
        if (skidCnt == '0) begin
          upUnblock = 1'b1;
          decState  = ST_RUN;
        end else begin
          decState = ST_UNBLOCKING;
        end
      end else if (stateQ == ST_SQUASHING) begin
        decState = ST_RUN;
      end

      if (decState == ST_UNBLOCKING) begin
        ctl.fromSkid = 1'b1;
        ctl.outCnt   = drainN;
        ctl.popCnt   = drainN;
        ctl.pushCnt  = liveCnt;
        if (remain == '0) begin
          upUnblock = 1'b1;
          nextState = ST_RUN;
        end else begin
          nextState = ST_UNBLOCKING;
        end
      end else begin
        ctl.outCnt = fwdN;
        if (liveCnt > WC) begin
          ctl.pushStart = WC;
          ctl.pushCnt   = liveCnt - WC;
          nextState     = ST_BLOCKED;
          // Resume and stop in one cycle cancel: upstream stays stopped.
          if (upUnblock) upUnblock = 1'b0;
          else           upBlock   = 1'b1;
        end else begin
          nextState = decState;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      stallQ <= '0;
    end else begin
      stateQ <= nextState;
      stallQ <= stallUpd;
    end
  end

  assign state = stateQ;

endmodule

// File: rtl/skid_stage_dp.sv
module skid_stage_dp
  import skid_stage_pkg::*;
#(
  parameter int FW    = 4,
  parameter int W     = 2,
  parameter int DW    = 8,
  parameter int DEPTH = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [FW-1:0]        inValid,
  input  logic [FW-1:0]        inKill,
  input  logic [FW-1:0][DW-1:0] inData,
  input  dpCtl_t               ctl,
  output logic [CNT_W-1:0]     liveCnt,
  output logic [CNT_W-1:0]     skidCnt,
  output logic [W-1:0]         outValid,
  output logic [W-1:0][DW-1:0] outData,
  output logic                 overflowErr
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W:0]   DEPTH_X = (CNT_W+1)'(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  function automatic logic [PW-1:0] wrapAdd(input logic [PW-1:0] p,
                                            input logic [CNT_W-1:0] off);
    logic [CNT_W:0] s;
    s = (CNT_W+1)'(p) + (CNT_W+1)'(off);
    if (s >= DEPTH_X) s = s - DEPTH_X;
    return s[PW-1:0];
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] countQ;
  logic ovfQ;

  logic [FW-1:0] live;
  logic [FW-1:0][CNT_W-1:0] rank;
  logic [FW-1:0][DW-1:0] liveData, pushData;
  logic [FW-1:0][PW-1:0] wrIdx;
  logic [W-1:0][PW-1:0]  rdIdx;
  logic [CNT_W-1:0] kept, room, nWrite;

  assign live = inValid & ~inKill;

  // Compact live entries toward slot 0, keeping arrival order.
  always_comb begin
    logic [CNT_W-1:0] run;
    run = '0;
    for (int i = 0; i < FW; i++) begin
      rank[i] = run;
      run     = run + CNT_W'(live[i]);
    end
    liveCnt = run;
  end

  always_comb begin
    liveData = '0;
    for (int k = 0; k < FW; k++)
      for (int i = 0; i < FW; i++)
        if (live[i] && rank[i] == CNT_W'(k)) liveData[k] = inData[i];
  end

  always_comb begin
    pushData = '0;
    for (int k = 0; k < FW; k++)
      for (int m = 0; m < FW; m++)
        if (CNT_W'(m) == ctl.pushStart + CNT_W'(k)) pushData[k] = liveData[m];
  end

  assign kept   = countQ - ctl.popCnt;
  assign room   = DEPTH_C - kept;
  assign nWrite = (ctl.pushCnt > room) ? room : ctl.pushCnt;

  for (genvar k = 0; k < FW; k++) begin : g_wr
    assign wrIdx[k] = wrapAdd(wrPtr, CNT_W'(k));
  end

  for (genvar j = 0; j < W; j++) begin : g_lane
    assign rdIdx[j]    = wrapAdd(rdPtr, CNT_W'(j));
    assign outValid[j] = (CNT_W'(j) < ctl.outCnt);
    if (j < FW) begin : g_direct
      assign outData[j] = ctl.fromSkid ? mem[rdIdx[j]] : liveData[j];
    end else begin : g_skidonly
      assign outData[j] = ctl.fromSkid ? mem[rdIdx[j]] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!ctl.flush)
      for (int k = 0; k < FW; k++)
        if (CNT_W'(k) < nWrite) mem[wrIdx[k]] <= pushData[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      countQ <= '0;
      ovfQ   <= 1'b0;
    end else if (ctl.flush) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      countQ <= '0;
    end else begin
      rdPtr  <= wrapAdd(rdPtr, ctl.popCnt);
      wrPtr  <= wrapAdd(wrPtr, nWrite);
      countQ <= kept + nWrite;
      if (ctl.pushCnt > room) ovfQ <= 1'b1;
    end
  end

  assign skidCnt     = countQ;
  assign overflowErr = ovfQ;

endmodule

// File: rtl/skid_stage.sv
module skid_stage
  import skid_stage_pkg::*;
#(
  parameter int FW  = 4,
  parameter int W   = 2,
  parameter int LAT = 1,
  parameter int DW  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FW-1:0]         inValid,
  input  logic [FW-1:0]         inKill,
  input  logic [FW-1:0][DW-1:0] inData,
  input  logic [2:0]            blockReq,
  input  logic [2:0]            unblockReq,
  input  logic                  squashCmd,
  input  logic                  squashHold,
  output logic [W-1:0]          outValid,
  output logic [W-1:0][DW-1:0]  outData,
  output logic                  upBlock,
  output logic                  upUnblock,
  output logic                  stageActive,
  output logic                  overflowErr,
  output logic [2:0]            stateOut
);

  localparam int DEPTH = LAT * FW + W;

  dpCtl_t ctl;
  stageState_e state;
  logic [CNT_W-1:0] liveCnt, skidCnt;

  skid_stage_ctrl #(.W(W), .NSRC(3)) ctrl_i (
    .clk(clk), .rstN(rstN), .blockReq(blockReq), .unblockReq(unblockReq),
    .squashCmd(squashCmd), .squashHold(squashHold), .liveCnt(liveCnt),
    .skidCnt(skidCnt), .ctl(ctl), .upBlock(upBlock), .upUnblock(upUnblock),
    .state(state)
  );

  skid_stage_dp #(.FW(FW), .W(W), .DW(DW), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inKill(inKill),
    .inData(inData), .ctl(ctl), .liveCnt(liveCnt), .skidCnt(skidCnt),
    .outValid(outValid), .outData(outData), .overflowErr(overflowErr)
  );

  assign stateOut    = state;
  assign stageActive = (state == ST_UNBLOCKING);

endmodule

// File: rtl/skid_stage_chk.sv
module skid_stage_chk #(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rstN,
  input logic [2:0]   blockReq,
  input logic [2:0]   unblockReq,
  input logic         squashCmd,
  input logic         squashHold,
  input logic [W-1:0] outValid,
  input logic         upBlock,
  input logic         upUnblock,
  input logic         stageActive,
  input logic         overflowErr,
  input logic [2:0]   stateOut
);

  assert_no_dual_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(upBlock && upUnblock));

  assert_squash_enters_R7: assert property (@(posedge clk) disable iff (!rstN)
    squashCmd |=> stateOut == 3'd4);

  assert_squash_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    squashCmd |-> outValid == '0);

  assert_hold_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (squashHold && !squashCmd) |=> stateOut == 3'd4);

  assert_lanes_packed_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((({1'b0, outValid}) + 1'b1) & {1'b0, outValid}) == '0);

  assert_stall_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((blockReq & ~unblockReq) != 3'b0 && !squashCmd && !squashHold)
      |-> outValid == '0);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

  assert_unblock_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stageActive) |-> $past(stateOut) == 3'd2);

endmodule

bind skid_stage skid_stage_chk #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .blockReq(blockReq), .unblockReq(unblockReq),
  .squashCmd(squashCmd), .squashHold(squashHold), .outValid(outValid),
  .upBlock(upBlock), .upUnblock(upUnblock), .stageActive(stageActive),
  .overflowErr(overflowErr), .stateOut(stateOut)
);

// File: tb/skid_stage_tb_top.sv
module skid_stage_tb_top;

  localparam int FW = 4;
  localparam int W = 2;
  localparam int LAT = 1;
  localparam int DW = 8;
  localparam int DEPTH = LAT * FW + W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [FW-1:0] inValid = '0, inKill = '0;
  logic [FW-1:0][DW-1:0] inData = '0;
  logic [2:0] blockReq = '0, unblockReq = '0;
  logic squashCmd = 1'b0, squashHold = 1'b0;
  logic [W-1:0] outValid;
  logic [W-1:0][DW-1:0] outData;
  logic upBlock, upUnblock, stageActive, overflowErr;
  logic [2:0] stateOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] seq = '0;

  // reference model state
  int mState;
  bit [2:0] mStall;
  bit mOvf;
  int skidQ[$];

  always #2.5 clk = ~clk;

  skid_stage #(.FW(FW), .W(W), .LAT(LAT), .DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inKill(inKill), .inData(inData),
    .blockReq(blockReq), .unblockReq(unblockReq), .squashCmd(squashCmd),
    .squashHold(squashHold), .outValid(outValid), .outData(outData),
    .upBlock(upBlock), .upUnblock(upUnblock), .stageActive(stageActive),
    .overflowErr(overflowErr), .stateOut(stateOut)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = '0; inKill = '0; blockReq = '0; unblockReq = '0;
    squashCmd = 1'b0; squashHold = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mState = 0; mStall = '0; mOvf = 0; skidQ = {};
    #1;
    check("R1", "state after reset", int'(stateOut), 0);
    check("R1", "outValid after reset", int'(outValid), 0);
    check("R1", "pulses after reset", int'({upBlock, upUnblock}), 0);
    check("R1", "active/overflow after reset", int'({stageActive, overflowErr}), 0);
    check("R12", "Idle encodes as 0", int'(stateOut), 0);
    @(negedge clk);
  endtask

  // One cycle: drive at negedge, predict and compare, then advance the model.
  task automatic step(input logic [FW-1:0] v, input logic [FW-1:0] k,
                      input logic [2:0] b, input logic [2:0] u,
                      input logic sq, input logic hd);
    int live[$];
    int expOut[$];
    int newSkid[$];
    bit [2:0] stallU;
    bit eB, eU, ovf;
    int nState, decState;
    string tag;
    inValid = v; inKill = k; blockReq = b; unblockReq = u;
    squashCmd = sq; squashHold = hd;
    for (int i = 0; i < FW; i++) begin
      inData[i] = seq;
      if (v[i] && !k[i]) live.push_back(int'(seq));
      seq = seq + 1'b1;
    end
    #1;
    stallU = (mStall | b) & ~u;
    eB = 0; eU = 0; ovf = 0; nState = mState;
    newSkid = skidQ;
    if (sq || hd) begin
      tag = sq ? "R7" : "R8";
      newSkid = {};
      nState = 4;
      eU = (mState == 2 || mState == 3);
    end else if (stallU != 0) begin
      tag = (mState == 4) ? "R9" : "R3";
      foreach (live[i]) if (newSkid.size() < DEPTH) newSkid.push_back(live[i]); else ovf = 1;
      eB = (mState != 2);
      nState = 2;
    end else begin
      tag = "R2";
      decState = mState;
      if (mState == 2) begin
        tag = "R5";
        if (skidQ.size() == 0) begin eU = 1; decState = 1; end
        else decState = 3;
      end else if (mState == 4) begin
        tag = "R9"; decState = 1;
      end
      if (decState == 3) begin
        if (mState == 3) tag = "R6";
        while (expOut.size() < W && newSkid.size() > 0) expOut.push_back(newSkid.pop_front());
        foreach (live[i]) if (newSkid.size() < DEPTH) newSkid.push_back(live[i]); else ovf = 1;
        if (newSkid.size() == 0) begin eU = 1; nState = 1; end else nState = 3;
      end else begin
        foreach (live[i]) begin
          if (expOut.size() < W) expOut.push_back(live[i]);
          else if (newSkid.size() < DEPTH) newSkid.push_back(live[i]);
          else ovf = 1;
        end
        if (live.size() > W) begin
          nState = 2;
          if (eU) begin eU = 0; tag = "R11"; end
          else begin eB = 1; if (tag == "R2") tag = "R4"; end
        end else nState = decState;
      end
    end
    if (ovf) tag = "R10";
    check(tag, "stateOut", int'(stateOut), mState);
    check(tag, "stageActive", int'(stageActive), int'(mState == 3));
    check(tag, "overflowErr", int'(overflowErr), int'(mOvf));
    check(tag, "outValid", int'(outValid), (1 << expOut.size()) - 1);
    foreach (expOut[j]) check(tag, "outData lane", int'(outData[j]), expOut[j]);
    check(tag, "upBlock", int'(upBlock), int'(eB));
    check(tag, "upUnblock", int'(upUnblock), int'(eU));
    @(posedge clk);
    mState = nState; mStall = stallU; skidQ = newSkid; mOvf = mOvf | ovf;
    @(negedge clk);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R2: Idle forwards live entries in order, killed ones skipped
    step(4'b0101, 4'b0000, 3'b000, 3'b000, 0, 0);
    step(4'b1111, 4'b0110, 3'b000, 3'b000, 0, 0);
    // R4: more than W live entries blocks
    step(4'b1111, 4'b0000, 3'b000, 3'b000, 0, 0);
    check("R4", "state Blocked after surplus", int'(stateOut), 2);
    // R5/R6: drain skid then resume
    step(4'b0001, 4'b0000, 3'b000, 3'b000, 0, 0);
    step(4'b0000, 4'b0000, 3'b000, 3'b000, 0, 0);
    step(4'b0000, 4'b0000, 3'b000, 3'b000, 0, 0);
    // R11: Blocked with empty skid then surplus arrives
    step(4'b0000, 4'b0000, 3'b010, 3'b000, 0, 0);
    step(4'b1111, 4'b0000, 3'b000, 3'b010, 0, 0);
    check("R11", "stays Blocked, no pulse", int'(stateOut), 2);
    // R7: squash while Blocked, then R9 exit
    step(4'b1111, 4'b0000, 3'b000, 3'b000, 1, 0);
    step(4'b0011, 4'b0000, 3'b000, 3'b000, 0, 1);
    step(4'b0011, 4'b0000, 3'b000, 3'b000, 0, 0);
    // R10: long stall with full bundles overflows
    step(4'b1111, 4'b0000, 3'b100, 3'b000, 0, 0);
    step(4'b1111, 4'b0000, 3'b000, 3'b000, 0, 0);
    step(4'b1111, 4'b0000, 3'b000, 3'b100, 0, 0);
    check("R10", "overflow flag set", int'(overflowErr), 1);
    for (int s = 0; s < 8; s++) step(4'b0000, 4'b0000, 3'b000, 3'b000, 0, 0);

    // Random sweeps at several stall densities, reset between epochs
    for (int e = 0; e < 6; e++) begin
      doReset();
      for (int c = 0; c < 600; c++) begin
        logic [2:0] b, u;
        logic sq, hd;
        b = '0; u = '0;
        for (int s = 0; s < 3; s++) begin
          if ($urandom_range(0, 31) < 1 + e) b[s] = 1'b1;
          if (mStall[s] && $urandom_range(0, 3) < 2) u[s] = 1'b1;
        end
        sq = ($urandom_range(0, 39) == 0);
        hd = ($urandom_range(0, 49) == 0);
        step(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15) & $urandom_range(0, 15)),
             b, u, sq, hd);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule